// File: doc/BRIEF.md
# Parity-Checked Serial Word Receiver

This block turns 20-bit words arriving one bit at a time on a telemetry line into two parallel 16-bit words for a host. Bits are delivered as a single-clock strobe with a sampled data value, already in the block's clock domain. A word opens with a header bit of value 1. Eighteen payload bits follow, most significant first: a 6-bit channel number and then three 4-bit BCD digits M, N and E, which together express M.N × 10^-E. The word closes with one parity bit.

When the last bit arrives, the block latches a status word and a data word. The status word holds the channel, a parity-error flag and a timeout flag. The block then raises a data-ready flag and pulses a one-clock valid strobe. A word that stalls part-way is ended by a timeout and reported as such.

The host empties the receiver with a clear request. A clear that would land in the middle of a word is not lost. It is held back and applied once the line has gone quiet, so the host never tears a reception in half.

Top module: `serial_word_rx`

## Requirements
- R1: While idle, a strobe whose data bit is 1 starts a word and drives `rxBusy` high from the next clock. An idle strobe whose data bit is 0 is ignored: `rxBusy` stays low and the output words are unchanged.
- R2: On a normal completion, `statusWord[5:0]` holds the first six payload bits. `dataWord[11:8]`, `[7:4]` and `[3:0]` hold the next three 4-bit groups, in arrival order. All other bits are 0, apart from bit 15 of the status word (R3).
- R3: The expected parity bit makes the header, the 18 payload bits and the parity bit together contain an even number of ones. On a mismatch, `statusWord[15]` is set to 1; otherwise it is 0.
- R4: The outputs update at the clock edge that samples the 20th bit. `dataReady` goes to 1 and stays there, and `dataValid` is 1 for exactly that one cycle.
- R5: If the 20th bit has not been sampled by the TIMEOUT_CYCLES-th clock edge after the header edge, the word is dropped at that edge. `statusWord` becomes 16'h4000 (bit 14 set), `dataWord` becomes 0, `dataReady` is set and `dataValid` pulses. A 20th bit sampled exactly at that edge completes the word normally.
- R6: A host clear applied while idle, with the hold-off expired, sets `dataReady`, `statusWord` and `dataWord` to 0 at the next clock edge.
- R7: A host clear raised while a word is in flight, or within HOLDOFF_CYCLES clocks of the last strobe, is remembered. It has no effect until HOLDOFF_CYCLES clock edges have passed after the most recent strobe. It then clears as in R6.
- R8: After reset, all outputs are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitStrobe | input | 1 | One-clock pulse marking a received bit cell |
| bitData | input | 1 | Bit value sampled with `bitStrobe` |
| hostClear | input | 1 | Host request to empty the receiver |
| statusWord | output | 16 | Parity error [15], timeout [14], channel [5:0] |
| dataWord | output | 16 | Digits M [11:8], N [7:4], E [3:0] |
| dataReady | output | 1 | A word (or timeout report) is held |
| dataValid | output | 1 | One-clock pulse when a word is latched |
| rxBusy | output | 1 | Reception in progress |

## Verification
Two events can land on the same clock edge: the final bit of a word and the expiry of the stall timer. The bench provokes this by spacing the bits so that the 20th strobe lands exactly TIMEOUT_CYCLES edges after the header. It expects a normal completion there. The same word is then sent one clock later, with a parity bit of 0, and the bench expects a timeout report with the late strobe ignored. A second overlap, a host clear raised mid-word, is judged by checking that the freshly latched word survives the hold-off and disappears only after it.

// File: rtl/wordrx_pkg.sv
package wordrx_pkg;
  localparam int OUT_W = 16;

  typedef struct packed {
    logic startWord;
    logic shiftBit;
    logic finishWord;
    logic timeoutHit;
    logic clearOut;
  } rxCtrlT;
endpackage

// File: rtl/wordrx_ctrl.sv
module wordrx_ctrl
  import wordrx_pkg::*;
#(
  parameter int WORD_BITS      = 20,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int HOLDOFF_CYCLES = 300
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitStrobe,
  input  logic   bitData,
  input  logic   hostClear,
  output rxCtrlT ctrl,
  output logic   rxBusy
);
  localparam int IDX_W  = $clog2(WORD_BITS);
  localparam int TIME_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLDOFF_CYCLES + 1);

  logic              busyQ;
  logic [IDX_W-1:0]  bitIdx;
  logic [TIME_W-1:0] timeCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              clrPending;
  logic              lastBit;
  logic              timeLimit;
  logic              inhibit;

  always_comb begin
    lastBit         = (bitIdx == IDX_W'(WORD_BITS - 1));
    timeLimit       = busyQ && (timeCnt == TIME_W'(TIMEOUT_CYCLES - 1));
    inhibit         = busyQ || (holdCnt != '0) || bitStrobe;
    ctrl.startWord  = !busyQ && bitStrobe && bitData;
    ctrl.finishWord = busyQ && bitStrobe && lastBit;
    ctrl.timeoutHit = timeLimit && !ctrl.finishWord;
    ctrl.shiftBit   = busyQ && bitStrobe && !lastBit && !timeLimit;
    ctrl.clearOut   = (hostClear || clrPending) && !inhibit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      bitIdx  <= '0;
      timeCnt <= '0;
    end else begin
      if (ctrl.startWord) begin
        busyQ   <= 1'b1;
        bitIdx  <= IDX_W'(1);
        timeCnt <= '0;
      end else begin
        if (ctrl.finishWord || ctrl.timeoutHit) busyQ <= 1'b0;
        if (ctrl.shiftBit) bitIdx <= bitIdx + IDX_W'(1);
        if (busyQ) timeCnt <= timeCnt + TIME_W'(1);
      end
    end
  end

  // Retriggerable hold-off: every bit cell restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt    <= '0;
      clrPending <= 1'b0;
    end else begin
      if (bitStrobe) holdCnt <= HOLD_W'(HOLDOFF_CYCLES);
      else if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);

      if (ctrl.clearOut) clrPending <= 1'b0;
      else if (hostClear && inhibit) clrPending <= 1'b1;
    end
  end

  assign rxBusy = busyQ;
endmodule

// File: rtl/wordrx_dp.sv
module wordrx_dp
  import wordrx_pkg::*;
#(
  parameter int CHAN_W  = 6,
  parameter int DIGIT_W = 4,
  parameter int DIGITS  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitData,
  input  rxCtrlT           ctrl,
  output logic [OUT_W-1:0] statusWord,
  output logic [OUT_W-1:0] dataWord,
  output logic             dataReady,
  output logic             dataValid
);
  localparam int NUM_W     = DIGITS * DIGIT_W;
  localparam int DATA_BITS = CHAN_W + NUM_W;
  localparam int PE_POS    = OUT_W - 1;
  localparam int TE_POS    = OUT_W - 2;

  logic [DATA_BITS-1:0] shiftQ;
  logic                 parAcc;
  logic [OUT_W-1:0]     statusNext;
  logic [OUT_W-1:0]     dataNext;
  logic [NUM_W-1:0]     digitField;

  // Digits are packed in arrival order, most significant group first.
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign digitField[g*DIGIT_W +: DIGIT_W] = shiftQ[g*DIGIT_W +: DIGIT_W];
  end

  always_comb begin
    statusNext                 = '0;
    statusNext[PE_POS]         = parAcc ^ bitData;
    statusNext[CHAN_W-1:0]     = shiftQ[DATA_BITS-1 -: CHAN_W];
    dataNext                   = '0;
    dataNext[NUM_W-1:0]        = digitField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      parAcc <= 1'b0;
    end else if (ctrl.startWord) begin
      shiftQ <= '0;
      parAcc <= 1'b1;
    end else if (ctrl.shiftBit) begin
      shiftQ <= {shiftQ[DATA_BITS-2:0], bitData};
      parAcc <= parAcc ^ bitData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= '0;
      dataWord   <= '0;
      dataReady  <= 1'b0;
      dataValid  <= 1'b0;
    end else begin
      dataValid <= ctrl.finishWord || ctrl.timeoutHit;
      if (ctrl.finishWord) begin
        statusWord <= statusNext;
        dataWord   <= dataNext;
        dataReady  <= 1'b1;
      end else if (ctrl.timeoutHit) begin
        statusWord         <= '0;
        statusWord[TE_POS] <= 1'b1;
        dataWord           <= '0;
        dataReady          <= 1'b1;
      end else if (ctrl.clearOut) begin
        statusWord <= '0;
        dataWord   <= '0;
        dataReady  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import wordrx_pkg::*;
#(
  parameter int CHAN_W         = 6,
  parameter int DIGIT_W        = 4,
  parameter int DIGITS         = 3,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int HOLDOFF_CYCLES = 300
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitStrobe,
  input  logic        bitData,
  input  logic        hostClear,
  output logic [15:0] statusWord,
  output logic [15:0] dataWord,
  output logic        dataReady,
  output logic        dataValid,
  output logic        rxBusy
);
  localparam int WORD_BITS = CHAN_W + DIGITS * DIGIT_W + 2;

  rxCtrlT ctrl;

  wordrx_ctrl #(
    .WORD_BITS(WORD_BITS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitData(bitData),
    .hostClear(hostClear), .ctrl(ctrl), .rxBusy(rxBusy)
  );

  wordrx_dp #(
    .CHAN_W(CHAN_W), .DIGIT_W(DIGIT_W), .DIGITS(DIGITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .bitData(bitData), .ctrl(ctrl),
    .statusWord(statusWord), .dataWord(dataWord),
    .dataReady(dataReady), .dataValid(dataValid)
  );
endmodule

// File: rtl/wordrx_checker.sv
module wordrx_checker #(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input logic        clk,
  input logic        rstN,
  input logic        bitStrobe,
  input logic        bitData,
  input logic [15:0] statusWord,
  input logic [15:0] dataWord,
  input logic        dataReady,
  input logic        dataValid,
  input logic        rxBusy
);
  localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 2) + 1;
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (!rxBusy) busyRun <= '0;
    else if (busyRun != '1) busyRun <= busyRun + RUN_W'(1);
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!rxBusy && bitStrobe && bitData) |=> rxBusy);

  p_zero_ignored_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!rxBusy && bitStrobe && !bitData) |=> (!rxBusy && $stable(statusWord)));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  p_valid_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> dataReady);

  p_busy_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(TIMEOUT_CYCLES));

  p_timeout_fields_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && statusWord[14]) |-> (!statusWord[15] && statusWord[13:0] == '0 && dataWord == '0));

  p_hold_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxBusy && dataReady) |=> dataReady);
endmodule

bind serial_word_rx wordrx_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitData(bitData),
  .statusWord(statusWord), .dataWord(dataWord), .dataReady(dataReady),
  .dataValid(dataValid), .rxBusy(rxBusy)
);

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC     = 120;
  localparam int HOLD_CYC   = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitStrobe = 1'b0;
  logic        bitData = 1'b0;
  logic        hostClear = 1'b0;
  logic [15:0] statusWord;
  logic [15:0] dataWord;
  logic        dataReady;
  logic        dataValid;
  logic        rxBusy;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 1'b0;
  int unsigned seedDummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_rx #(.TIMEOUT_CYCLES(TO_CYC), .HOLDOFF_CYCLES(HOLD_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitData(bitData),
    .hostClear(hostClear), .statusWord(statusWord), .dataWord(dataWord),
    .dataReady(dataReady), .dataValid(dataValid), .rxBusy(rxBusy)
  );

  function automatic logic parityFor(logic [17:0] d);
    return 1'b1 ^ (^d);
  endfunction

  function automatic logic [15:0] expStatus(logic [17:0] d, logic bad);
    return {bad, 9'b0, d[17:12]};
  endfunction

  function automatic logic [15:0] expData(logic [17:0] d);
    return {4'b0, d[11:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns gap negedges later.
  task automatic sendBit(logic b, int gap);
    bitStrobe = 1'b1;
    bitData   = b;
    @(negedge clk);
    bitStrobe = 1'b0;
    bitData   = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic sendWord(logic [17:0] d, logic flip, int gap, int lastGap);
    sendBit(1'b1, gap);
    check("R1 busy after header", {31'b0, rxBusy}, 32'd1);
    for (int i = 17; i >= 0; i--) sendBit(d[i], (i == 0) ? lastGap : gap);
    sendBit(parityFor(d) ^ flip, 1);
  endtask

  task automatic checkWord(string req, logic [17:0] d, logic flip);
    check({req, " valid pulse R4"}, {31'b0, dataValid}, 32'd1);
    check({req, " ready R4"}, {31'b0, dataReady}, 32'd1);
    check({req, " status R2/R3"}, {16'b0, statusWord}, {16'b0, expStatus(d, flip)});
    check({req, " data R2"}, {16'b0, dataWord}, {16'b0, expData(d)});
    check({req, " idle R1"}, {31'b0, rxBusy}, 32'd0);
    @(negedge clk);
    check({req, " valid drops R4"}, {31'b0, dataValid}, 32'd0);
  endtask

  task automatic pulseClear();
    hostClear = 1'b1;
    @(negedge clk);
    hostClear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [17:0] d;
    seedDummy = $urandom(32'd20251);
    repeat (3) @(negedge clk);
    check("R8 status at reset", {16'b0, statusWord}, 32'd0);
    check("R8 data at reset", {16'b0, dataWord}, 32'd0);
    check("R8 flags at reset", {28'b0, dataReady, dataValid, rxBusy, 1'b0}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed word: channel 0x2A, M=9 N=3 E=7
    d = {6'h2A, 4'd9, 4'd3, 4'd7};
    sendWord(d, 1'b0, 3, 3);
    checkWord("directed", d, 1'b0);

    // Corrupted parity R3
    d = {6'h15, 4'd1, 4'd2, 4'd4};
    sendWord(d, 1'b1, 2, 2);
    checkWord("bad parity R3", d, 1'b1);

    // Idle zero strobes are ignored R1
    for (int k = 0; k < 3; k++) sendBit(1'b0, 3);
    check("R1 zero strobe no busy", {31'b0, rxBusy}, 32'd0);
    check("R1 zero strobe status kept", {16'b0, statusWord}, {16'b0, expStatus(d, 1'b1)});

    // Idle clear R6
    repeat (HOLD_CYC + 2) @(negedge clk);
    pulseClear();
    check("R6 ready cleared", {31'b0, dataReady}, 32'd0);
    check("R6 status cleared", {16'b0, statusWord}, 32'd0);
    check("R6 data cleared", {16'b0, dataWord}, 32'd0);

    // Deferred clear R7
    d = {6'h3F, 4'd8, 4'd0, 4'd5};
    sendBit(1'b1, 3);
    for (int i = 17; i >= 12; i--) sendBit(d[i], 3);
    pulseClear();
    for (int i = 11; i >= 0; i--) sendBit(d[i], 3);
    sendBit(parityFor(d), 1);
    checkWord("deferred clear R7", d, 1'b0);
    repeat (HOLD_CYC / 2) @(negedge clk);
    check("R7 word held in hold-off", {31'b0, dataReady}, 32'd1);
    repeat (HOLD_CYC + 2) @(negedge clk);
    check("R7 deferred clear applied", {31'b0, dataReady}, 32'd0);
    check("R7 status after deferred clear", {16'b0, statusWord}, 32'd0);

    // Final bit exactly at the timeout edge completes R5
    d = {6'h07, 4'd4, 4'd5, 4'd6};
    sendWord(d, 1'b0, 6, TO_CYC - 18 * 6);
    checkWord("boundary R5", d, 1'b0);

    // One clock later: timeout, trailing zero parity strobe ignored R5
    d = 18'h01000;
    repeat (HOLD_CYC + 2) @(negedge clk);
    sendWord(d, 1'b0, 6, TO_CYC - 18 * 6 + 1);
    check("R5 late status", {16'b0, statusWord}, 32'h4000);
    check("R5 late data", {16'b0, dataWord}, 32'd0);
    check("R5 late ready", {31'b0, dataReady}, 32'd1);
    check("R5 late idle", {31'b0, rxBusy}, 32'd0);

    // Stalled partial word R5
    repeat (HOLD_CYC + 2) @(negedge clk);
    pulseClear();
    check("R6 clear before stall", {31'b0, dataReady}, 32'd0);
    sendBit(1'b1, 4);
    for (int k = 0; k < 4; k++) sendBit(1'b1, 4);
    repeat (TO_CYC) @(negedge clk);
    check("R5 stall status", {16'b0, statusWord}, 32'h4000);
    check("R5 stall ready", {31'b0, dataReady}, 32'd1);
    check("R5 stall idle", {31'b0, rxBusy}, 32'd0);

    // Random words R2 R3 R4
    for (int n = 0; n < 40; n++) begin
      logic [17:0] rd;
      logic        rf;
      int          gp;
      rd = 18'($urandom);
      rf = (($urandom % 4) == 0);
      gp = 2 + int'($urandom % 4);
      sendWord(rd, rf, gp, gp);
      checkWord("random R2", rd, rf);
      repeat ($urandom % 5) @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule